// File: doc/BRIEF.md
# Auto-Direction Open-Drain Bridge Controller

This block decides, in synchronous logic, which end of a single bidirectional open-drain data line is driving. One end of the line belongs to a host and the other to a card. Each end gives the controller a sampled line level and receives an active-high pull-low enable. No input selects the direction. The line stays idle until one end pulls low. That end becomes the owner, and the controller pulls the other end low for as long as the owner holds the line low.

When the owner lets go, the controller releases the mirrored end. It then raises a boost strobe on that end for a set number of cycles to speed up the rising edge. Ownership can move to the other end only after the controller has seen both ends high. If both ends are forced low at once, the controller does not lock up: it waits until both lines are high again and then becomes idle.

Two one-way channels carry the host's reset and clock to the card. They are registered and have no arbitration. A low enable puts the block in shutdown: the card-side outputs are forced low and every pull toward the host is released.

Top module: `od_bridge_ctrl`

## Requirements
- R1: While reset is applied, every output is low: both pull enables, both boost strobes and the card reset and clock outputs.
- R2: From idle, a low on the host line asserts `card_pull_o` at the SYNC_STAGES+1-th clock edge after the low is present, and it stays asserted while the host line is low. `host_pull_o` stays low during this time, and the two pull enables are never high together.
- R3: From idle, a low on the card line asserts `host_pull_o` at the SYNC_STAGES+1-th edge, and `card_pull_o` stays low.
- R4: If both lines go low in the same sample cycle while idle, the host side wins: `card_pull_o` is asserted and `host_pull_o` stays low.
- R5: When the owner's line returns high, the mirrored pull is released at the SYNC_STAGES+1-th edge. At that same edge the boost strobe of the non-owning side (`card_boost_o` for a host owner, `host_boost_o` for a card owner) goes high and stays high for exactly PULSE_W cycles.
- R6: A falling edge on either sampled line during a boost pulse ends the pulse. The strobe is low from the edge after the one at which the new low level reaches the sampler output.
- R7: After the owner releases, a low still held on the other line is not mirrored, and both pull enables stay low. Once both lines have been seen high for a cycle, the block is idle again, and a new low on either side is mirrored as in R2 or R3.
- R8: One edge after `enable` is sampled low, `card_pull_o` is high and `host_pull_o`, both boosts, `card_rst_o` and `card_clk_o` are low, whatever the line and host inputs do.
- R9: While enabled, `card_rst_o` and `card_clk_o` equal `host_rst_i` and `host_clk_i` from one cycle earlier, independent of the data line.
- R10: When `enable` returns high, `card_pull_o` is released at the next edge. The low that the block itself left on the card line is not taken as a card request, so `host_pull_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | High for normal operation, low for shutdown |
| host_line_i | input | 1 | Level seen on the host end of the data line |
| card_line_i | input | 1 | Level seen on the card end of the data line |
| host_pull_o | output | 1 | Pull-low enable for the host end |
| card_pull_o | output | 1 | Pull-low enable for the card end |
| host_boost_o | output | 1 | Rising-edge boost strobe for the host end |
| card_boost_o | output | 1 | Rising-edge boost strobe for the card end |
| host_rst_i | input | 1 | Reset from the host |
| host_clk_i | input | 1 | Clock from the host |
| card_rst_o | output | 1 | Registered reset toward the card |
| card_clk_o | output | 1 | Registered clock toward the card |

## Verification
The bench builds the block with SYNC_STAGES=2 and PULSE_W=6, so a low is mirrored at the third edge. With this width a boost pulse lasts twice as long as the three-edge path from a fresh fall to cancellation. An early cancel therefore gives a different output from a pulse that simply runs out, which lets R6 be observed. The two-stage sampler also leaves a window in which the block's own card pull is still visible after a re-enable, and R10 relies on that window. Random traffic with held conflicts and short shutdowns is compared each cycle against a behavioural model driven through a wired-AND line model.

// File: rtl/adb_pkg.sv
`timescale 1ns/1ps
package adb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_HOST   = 2'd1,
    ARB_CARD   = 2'd2,
    ARB_SETTLE = 2'd3
  } arb_state_e;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_e;
endpackage

// File: rtl/adb_rst_sync.sv
`timescale 1ns/1ps
module adb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/adb_sampler.sv
`timescale 1ns/1ps
module adb_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = line_i;
    end else begin : g_chain
      assign chain_d = {chain_q[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adb_arbiter.sv
`timescale 1ns/1ps
module adb_arbiter
  import adb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lvl_host,
  input  logic lvl_card,
  output logic host_pull_o,
  output logic card_pull_o,
  output logic start_host_o,
  output logic start_card_o
);
  arb_state_e state_q, state_d;
  logic       host_pull_q, host_pull_d;
  logic       card_pull_q, card_pull_d;

  always_comb begin
    state_d     = state_q;
    host_pull_d = 1'b0;
    card_pull_d = 1'b0;
    if (!enable) begin
      // shutdown: hold the card end low, wait for both ends high afterwards
      state_d     = ARB_SETTLE;
      card_pull_d = 1'b1;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (!lvl_host) begin          // host wins a tie
            state_d     = ARB_HOST;
            card_pull_d = 1'b1;
          end else if (!lvl_card) begin
            state_d     = ARB_CARD;
            host_pull_d = 1'b1;
          end
        end
        ARB_HOST: begin
          if (lvl_host) state_d     = ARB_SETTLE;
          else          card_pull_d = 1'b1;
        end
        ARB_CARD: begin
          if (lvl_card) state_d     = ARB_SETTLE;
          else          host_pull_d = 1'b1;
        end
        default: begin
          if (lvl_host && lvl_card) state_d = ARB_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ARB_SETTLE;
      host_pull_q <= 1'b0;
      card_pull_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      host_pull_q <= host_pull_d;
      card_pull_q <= card_pull_d;
    end
  end

  assign host_pull_o  = host_pull_q;
  assign card_pull_o  = card_pull_q;
  assign start_card_o = enable && (state_q == ARB_HOST) && lvl_host;
  assign start_host_o = enable && (state_q == ARB_CARD) && lvl_card;

  // R2: never pull both ends at once
  p_excl_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_q && card_pull_q));

  // R2: the mirror holds while the host keeps its line low
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == ARB_HOST && !lvl_host) |=> card_pull_q);

  // R4: simultaneous lows go to the host side
  p_host_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == ARB_IDLE && !lvl_host && !lvl_card) |=> (card_pull_q && !host_pull_q));

  // R7: nothing is mirrored while waiting for both ends high
  p_settle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == ARB_SETTLE) |=> (!host_pull_q && !card_pull_q));

  // R8: shutdown pull pattern
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (card_pull_q && !host_pull_q));
endmodule

// File: rtl/adb_oneshot.sv
`timescale 1ns/1ps
module adb_oneshot
  import adb_pkg::*;
#(
  parameter int PULSE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_host,
  input  logic start_card,
  input  logic cancel,
  output logic boost_host,
  output logic boost_card
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  side_e         side_q, side_d;
  logic          active;

  always_comb begin
    cnt_d  = cnt_q;
    side_d = side_q;
    if (!enable) begin
      cnt_d = '0;
    end else if (start_host || start_card) begin
      cnt_d  = CW'(PULSE_W);
      side_d = start_card ? SIDE_CARD : SIDE_HOST;
    end else if (cancel) begin
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      side_q <= SIDE_HOST;
    end else begin
      cnt_q  <= cnt_d;
      side_q <= side_d;
    end
  end

  assign active     = (cnt_q != '0);
  assign boost_host = active && (side_q == SIDE_HOST);
  assign boost_card = active && (side_q == SIDE_CARD);

  // R5: a release launches the strobe on the far side
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_card) |=> boost_card);

  // R6: a new fall kills a running pulse
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cancel && !start_host && !start_card) |=> (!boost_host && !boost_card));
endmodule

// File: rtl/adb_fwd.sv
`timescale 1ns/1ps
module adb_fwd #(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CH-1:0] din,
  output logic [CH-1:0] dout
);
  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= enable & din[g];
    end
    assign dout[g] = q;
  end

  // R8: card-side channels are parked low in shutdown
  p_fwd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (dout == '0));

  // R9: one-cycle pass-through while enabled
  p_fwd_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (dout == $past(din)));
endmodule

// File: rtl/od_bridge_ctrl.sv
`timescale 1ns/1ps
module od_bridge_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_W     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic host_line_i,
  input  logic card_line_i,
  output logic host_pull_o,
  output logic card_pull_o,
  output logic host_boost_o,
  output logic card_boost_o,
  input  logic host_rst_i,
  input  logic host_clk_i,
  output logic card_rst_o,
  output logic card_clk_o
);
  localparam int NLINE  = 2;
  localparam int FWD_CH = 2;

  logic             rst_i;
  logic [NLINE-1:0] line_in, lvl, fall;
  logic             start_host, start_card;
  logic [FWD_CH-1:0] fwd_out;

  adb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  assign line_in = {card_line_i, host_line_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    adb_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_i), .line_i(line_in[g]),
      .level_o(lvl[g]), .fall_o(fall[g])
    );
  end

  adb_arbiter u_arb (
    .clk(clk), .rst_n(rst_i), .enable(enable),
    .lvl_host(lvl[0]), .lvl_card(lvl[1]),
    .host_pull_o(host_pull_o), .card_pull_o(card_pull_o),
    .start_host_o(start_host), .start_card_o(start_card)
  );

  adb_oneshot #(.PULSE_W(PULSE_W)) u_boost (
    .clk(clk), .rst_n(rst_i), .enable(enable),
    .start_host(start_host), .start_card(start_card),
    .cancel(|fall),
    .boost_host(host_boost_o), .boost_card(card_boost_o)
  );

  adb_fwd #(.CH(FWD_CH)) u_fwd (
    .clk(clk), .rst_n(rst_i), .enable(enable),
    .din({host_clk_i, host_rst_i}), .dout(fwd_out)
  );

  assign card_rst_o = fwd_out[0];
  assign card_clk_o = fwd_out[1];

  // R5: the card strobe starts exactly when the card mirror lets go
  p_boost_release_r5: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(card_boost_o) |-> ($past(card_pull_o) && !card_pull_o));

  // R1: everything quiet under reset
  always_comb begin
    if (!rst_i) begin
      p_reset_quiet_r1: assert (!host_pull_o && !card_pull_o && !host_boost_o &&
                                !card_boost_o && !card_rst_o && !card_clk_o);
    end
  end
endmodule

// File: tb/od_bridge_ctrl_test.sv
`timescale 1ns/1ps
module od_bridge_ctrl_test;
  localparam int SYNC = 2;
  localparam int PW   = 6;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n, enable, host_ext, card_ext, hrst, hclk;
  logic host_pull, card_pull, host_boost, card_boost, card_rst, card_clk;
  logic host_line, card_line;

  assign host_line = ~(host_ext | host_pull);
  assign card_line = ~(card_ext | card_pull);

  always #2.5 clk = ~clk;

  od_bridge_ctrl #(.SYNC_STAGES(SYNC), .PULSE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .host_line_i(host_line), .card_line_i(card_line),
    .host_pull_o(host_pull), .card_pull_o(card_pull),
    .host_boost_o(host_boost), .card_boost_o(card_boost),
    .host_rst_i(hrst), .host_clk_i(hclk),
    .card_rst_o(card_rst), .card_clk_o(card_clk)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model of the requirements
  logic m_sh [SYNC];
  logic m_sc [SYNC];
  logic m_ph, m_pc, m_hp, m_cp, m_side, m_rst, m_clk;
  int   m_st;    // 0 idle, 1 host owns, 2 card owns, 3 waiting for both high
  int   m_cnt;
  int   m_skip;

  task automatic model_reset();
    for (int i = 0; i < SYNC; i++) begin m_sh[i] = 1'b1; m_sc[i] = 1'b1; end
    m_ph = 1'b1; m_pc = 1'b1; m_st = 3; m_hp = 1'b0; m_cp = 1'b0;
    m_cnt = 0; m_side = 1'b0; m_rst = 1'b0; m_clk = 1'b0;
  endtask

  task automatic model_step();
    logic wl_h, wl_c, lh, lc, fh, fc, nhp, ncp, go_h, go_c;
    int   nst;
    wl_h = !(host_ext | m_hp);
    wl_c = !(card_ext | m_cp);
    lh = m_sh[SYNC-1];
    lc = m_sc[SYNC-1];
    fh = m_ph & !lh;
    fc = m_pc & !lc;
    nst = m_st; nhp = 1'b0; ncp = 1'b0; go_h = 1'b0; go_c = 1'b0;
    if (!enable) begin
      nst = 3; ncp = 1'b1;
    end else if (m_st == 0) begin
      if (!lh)      begin nst = 1; ncp = 1'b1; end
      else if (!lc) begin nst = 2; nhp = 1'b1; end
    end else if (m_st == 1) begin
      if (lh) begin nst = 3; go_c = 1'b1; end else ncp = 1'b1;
    end else if (m_st == 2) begin
      if (lc) begin nst = 3; go_h = 1'b1; end else nhp = 1'b1;
    end else if (lh && lc) begin
      nst = 0;
    end
    if (!enable)            m_cnt = 0;
    else if (go_h || go_c)  begin m_cnt = PW; m_side = go_c; end
    else if (fh || fc)      m_cnt = 0;
    else if (m_cnt > 0)     m_cnt = m_cnt - 1;
    m_ph = lh; m_pc = lc;
    for (int i = SYNC-1; i > 0; i--) begin m_sh[i] = m_sh[i-1]; m_sc[i] = m_sc[i-1]; end
    m_sh[0] = wl_h; m_sc[0] = wl_c;
    m_st = nst; m_hp = nhp; m_cp = ncp;
    m_rst = enable & hrst; m_clk = enable & hclk;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at the falling edge, step the model, compare at the next falling edge
  task automatic cyc(input logic eh, input logic ec, input logic en, input logic hr, input logic hc);
    host_ext = eh; card_ext = ec; enable = en; hrst = hr; hclk = hc;
    if (m_skip > 0) m_skip--;
    else            model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R2/R3 pull model", {6'b0, host_pull, card_pull}, {6'b0, m_hp, m_cp});
    chk("R5/R6 boost model", {6'b0, host_boost, card_boost},
        {6'b0, (m_cnt != 0) && !m_side, (m_cnt != 0) && m_side});
    chk("R9 forward model", {6'b0, card_rst, card_clk}, {6'b0, m_rst, m_clk});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    rst_n = 1'b0; enable = 1'b1; host_ext = 1'b0; card_ext = 1'b0; hrst = 1'b1; hclk = 1'b1;
    model_reset();
    m_skip = 0;
    repeat (4) @(negedge clk);
    // R1 reset state, with host inputs high
    chk("R1 reset outputs", {2'b0, host_pull, card_pull, host_boost, card_boost, card_rst, card_clk}, 8'h00);
    hrst = 1'b0; hclk = 1'b0;
    rst_n = 1'b1;
    m_skip = 2;
    idle(6);

    // R2 host takes the line
    for (int i = 0; i < LAT-1; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 no mirror yet", {7'b0, card_pull}, 8'h00);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 card mirrored", {6'b0, host_pull, card_pull}, 8'h01);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 mirror held", {6'b0, host_pull, card_pull}, 8'h01);

    // R5 release and boost width
    for (int i = 0; i < LAT-1; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 still mirrored", {6'b0, card_pull, card_boost}, 8'h02);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 released with boost", {6'b0, card_pull, card_boost}, 8'h01);
    for (int i = 0; i < PW-1; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 last boost cycle", {7'b0, card_boost}, 8'h01);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 boost ended", {7'b0, card_boost}, 8'h00);
    idle(4);

    // R3 card takes the line, host strobe on release
    for (int i = 0; i < LAT; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3 host mirrored", {6'b0, host_pull, card_pull}, 8'h02);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < LAT; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 host boost", {6'b0, host_pull, host_boost}, 8'h01);
    idle(PW + 4);

    // R4 tie, then R7 conflict recovery
    for (int i = 0; i < LAT; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R4 host priority", {6'b0, host_pull, card_pull}, 8'h01);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < LAT + 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 card low not mirrored", {6'b0, host_pull, card_pull}, 8'h00);
    idle(PW + 4);
    for (int i = 0; i < LAT; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 idle again after release", {6'b0, host_pull, card_pull}, 8'h02);
    idle(PW + 4);

    // R6 re-fall during the boost pulse
    for (int i = 0; i < LAT + 2; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < LAT; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 boost started", {7'b0, card_boost}, 8'h01);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 boost before fall seen", {7'b0, card_boost}, 8'h01);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 boost cut", {6'b0, card_boost, card_pull}, 8'h00);
    idle(PW + 4);

    // R8 shutdown
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 shutdown outputs", {2'b0, host_pull, card_pull, host_boost, card_boost, card_rst, card_clk}, 8'h10);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8 shutdown held", {2'b0, host_pull, card_pull, host_boost, card_boost, card_rst, card_clk}, 8'h10);

    // R10 re-enable
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 card released", {7'b0, card_pull}, 8'h00);
    idle(6);
    chk("R10 no false card owner", {6'b0, host_pull, card_pull}, 8'h00);
    for (int i = 0; i < LAT; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10 normal after re-enable", {7'b0, host_pull}, 8'h01);
    idle(PW + 4);

    // R9 pass-through
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 reset forwarded", {6'b0, card_rst, card_clk}, 8'h02);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 clock forwarded", {6'b0, card_rst, card_clk}, 8'h01);

    // random traffic against the model
    begin
      logic eh, ec, en;
      int   hold;
      eh = 1'b0; ec = 1'b0; en = 1'b1; hold = 0;
      for (int i = 0; i < 4000; i++) begin
        if (hold == 0) begin
          eh   = ($urandom % 3) == 0;
          ec   = ($urandom % 3) == 0;
          en   = ($urandom % 40) != 0;
          hold = 1 + ($urandom % 12);
        end
        hold--;
        cyc(eh, ec, en, 1'($urandom % 2), 1'($urandom % 2));
      end
    end
    idle(PW + 6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule